// File: doc/BRIEF.md
# Vector Load/Store Element Address Sequencer

This block takes one decoded vector memory request and turns it into a stream of per-element memory requests. Each request carries an effective address, the destination element number and a cache-inhibit flag. The request names a scalar base, a base vector, a scalar index, an index vector, a signed 16-bit immediate, a vector length and two predicate masks. Flags choose the immediate or the register-indexed form and say which operands are vectors. From these flags the block picks one of several addressing schemes: contiguous (unit stride), strided by the immediate, a vector of bases, indexed, or splat.

Two element counters run on their own. One walks the source (address) elements and the other walks the destination elements. Each counter can skip masked-out elements. Skipping costs no cycles, because every cycle the next enabled element is found in one step. The memory side takes each element through a valid/ready handshake. A one-cycle done pulse marks the end of the request. That pulse carries an illegal flag for the one operand combination that has no defined meaning.

Top module: `vldst_addr_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle and out of reset. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. After the last element a single-cycle `done` pulse is raised, and `req_ready` returns high in the next cycle.
- R2: Unit-stride mode (immediate form, scalar base, vector destination, stride flag low) gives source element i the address base + sign-extended immediate + i·bytes. The op-width code maps to bytes as 0→1, 1→2, 2→4, 3→8.
- R3: Element-strided mode (immediate form, scalar base, vector destination, stride flag high) gives source element i the address base + i·(sign-extended immediate).
- R4: In the immediate form with a vector base, source element i uses base-vector entry i plus the sign-extended immediate.
- R5: In the indexed form with a vector destination and at least one vector operand, source element i uses (base-vector entry i or the scalar base) plus (index-vector entry i or the scalar index), each chosen by its vector flag.
- R6: In the indexed form the index operand is first cut to its element width (code 0→8, 1→16, 2→32, 3→64 bits). It is then sign-extended when the signed-index flag is set and zero-extended otherwise. In the immediate form the index operands and these flags have no effect on the address.
- R7: Splat mode (indexed form, scalar base and index, vector destination) issues one separate request for every enabled destination element, all to the same address. The cache-inhibit flag of the request is copied onto every element request.
- R8: The source mask skips source elements only when an address operand is a vector. The destination mask skips destination elements only when the destination is a vector. Element pairs are issued in increasing order, and the request ends when either counter reaches the vector length.
- R9: With a scalar destination, at most one element request is issued. It carries destination index 0 and uses the first enabled source element.
- R10: The indexed form with a scalar destination and any vector operand issues no element requests. It ends with `done` and `done_illegal` both high.
- R11: A vector length of zero, or an enabled mask with no set bit below the vector length, issues no element requests. Such a request ends with `done` one cycle after acceptance.
- R12: While `elem_valid` is high and `elem_ready` is low, `elem_valid`, `elem_addr`, `elem_dst_idx` and `elem_nocache` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_indexed | input | 1 | 1 = register-indexed form, 0 = immediate form |
| req_elstride | input | 1 | Immediate form: 1 = stride by immediate, 0 = unit stride |
| req_base_isvec | input | 1 | Base operand is a vector |
| req_idx_isvec | input | 1 | Index operand is a vector |
| req_dst_isvec | input | 1 | Destination is a vector |
| req_signed_idx | input | 1 | Sign-extend the index in the indexed form |
| req_idx_width | input | 2 | Index element width code |
| req_op_width | input | 2 | Access width code (bytes = 1 << code) |
| req_nocache | input | 1 | Cache-inhibited access |
| req_imm | input | IMMW | Signed immediate |
| req_vl | input | VLW | Vector length, 0..VLMAX |
| req_src_mask | input | VLMAX | Source predicate |
| req_dst_mask | input | VLMAX | Destination predicate |
| req_base | input | AW | Scalar base |
| req_base_vec | input | VLMAX*AW | Base vector, entry i at bits i*AW |
| req_idx | input | AW | Scalar index |
| req_idx_vec | input | VLMAX*AW | Index vector, entry i at bits i*AW |
| elem_valid | output | 1 | Element request valid |
| elem_ready | input | 1 | Memory side accepts element |
| elem_addr | output | AW | Effective address |
| elem_dst_idx | output | IW | Destination element number |
| elem_nocache | output | 1 | Cache-inhibit flag of the element |
| done | output | 1 | Request finished (one cycle) |
| done_illegal | output | 1 | Finished request was an illegal combination |

## Verification
The bench runs negative immediates and negative indices, 16-bit and 32-bit index widths with the sign flag both set and clear, and sparse masks whose gaps differ on the source and destination sides. A design that extended indices the wrong way, or let the index leak into immediate-form addresses, would show wrong addresses. A design that tied the two counters together would issue the wrong destination numbers. Splat with cache inhibit checks that every destination element still gets its own request. The scalar-destination, illegal, zero-length and empty-mask cases catch a sequencer that issues a stray element or never raises done. Random back-pressure checks that payloads are held during stalls.

// File: rtl/vldst_pkg.sv
package vldst_pkg;

  typedef enum logic [2:0] {
    MD_UNIT    = 3'd0,
    MD_STRIDE  = 3'd1,
    MD_VBASE   = 3'd2,
    MD_SIMM    = 3'd3,
    MD_INDEX   = 3'd4,
    MD_SPLAT   = 3'd5,
    MD_SIDX    = 3'd6,
    MD_ILLEGAL = 3'd7
  } vmode_e;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_RUN  = 1'b1
  } seq_state_e;

endpackage

// File: rtl/vldst_rst_sync.sv
module vldst_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/vldst_mode_dec.sv
module vldst_mode_dec
  import vldst_pkg::*;
(
  input  logic   indexed,
  input  logic   elstride,
  input  logic   base_isvec,
  input  logic   idx_isvec,
  input  logic   dst_isvec,
  output vmode_e mode,
  output logic   src_skip,
  output logic   illegal
);
  always_comb begin
    mode     = MD_UNIT;
    src_skip = 1'b0;
    illegal  = 1'b0;
    if (!indexed) begin
      if (base_isvec) begin
        mode     = MD_VBASE;
        src_skip = 1'b1;
      end else if (!dst_isvec) begin
        mode = MD_SIMM;
      end else if (elstride) begin
        mode = MD_STRIDE;
      end else begin
        mode = MD_UNIT;
      end
    end else begin
      if (base_isvec || idx_isvec) begin
        if (dst_isvec) begin
          mode     = MD_INDEX;
          src_skip = 1'b1;
        end else begin
          mode    = MD_ILLEGAL;
          illegal = 1'b1;
        end
      end else begin
        mode = dst_isvec ? MD_SPLAT : MD_SIDX;
      end
    end
  end
endmodule

// File: rtl/vldst_next_set.sv
module vldst_next_set #(
  parameter int N  = 8,
  parameter int CW = 4,
  localparam int PW = $clog2(N)
) (
  input  logic [N-1:0]  mask,
  input  logic [CW-1:0] start,
  input  logic [CW-1:0] limit,
  input  logic          skip,
  output logic          found,
  output logic [PW-1:0] pos
);
  always_comb begin
    found = 1'b0;
    pos   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if ((CW'(k) >= start) && (CW'(k) < limit) && (mask[k] || !skip)) begin
        found = 1'b1;
        pos   = PW'(k);
      end
    end
  end
endmodule

// File: rtl/vldst_addr_gen.sv
module vldst_addr_gen
  import vldst_pkg::*;
#(
  parameter int AW    = 64,
  parameter int IMMW  = 16,
  parameter int VLMAX = 8,
  localparam int IW   = $clog2(VLMAX)
) (
  input  vmode_e              mode,
  input  logic [AW-1:0]       base,
  input  logic [VLMAX*AW-1:0] base_vec,
  input  logic                base_isvec,
  input  logic [AW-1:0]       idx,
  input  logic [VLMAX*AW-1:0] idx_vec,
  input  logic                idx_isvec,
  input  logic [1:0]          idx_wcode,
  input  logic                idx_signed,
  input  logic [1:0]          op_wcode,
  input  logic [IMMW-1:0]     imm,
  input  logic [IW-1:0]       pos,
  output logic [AW-1:0]       addr
);
  logic [AW-1:0] bv [VLMAX];
  logic [AW-1:0] iv [VLMAX];

  for (genvar g = 0; g < VLMAX; g++) begin : g_unpack
    assign bv[g] = base_vec[g*AW +: AW];
    assign iv[g] = idx_vec[g*AW +: AW];
  end

  logic [AW-1:0] imm_x, pos_x, a_op, b_raw, b_ext;
  logic          indexed_form;

  assign imm_x = {{(AW-IMMW){imm[IMMW-1]}}, imm};
  assign pos_x = AW'(pos);
  assign a_op  = base_isvec ? bv[pos] : base;
  assign b_raw = idx_isvec ? iv[pos] : idx;
  assign indexed_form = (mode == MD_INDEX) || (mode == MD_SPLAT) || (mode == MD_SIDX);

  // index cut to its element width, then sign or zero filled
  always_comb begin
    int wbits;
    wbits = 8 << idx_wcode;
    b_ext = b_raw;
    if (wbits < AW) begin
      for (int b = 0; b < AW; b++) begin
        if (b >= wbits) b_ext[b] = idx_signed ? b_raw[wbits-1] : 1'b0;
      end
    end
  end

  always_comb begin
    if (indexed_form) begin
      addr = a_op + b_ext;
    end else begin
      case (mode)
        MD_UNIT:   addr = base + imm_x + (pos_x << op_wcode);
        MD_STRIDE: addr = base + (pos_x * imm_x);
        default:   addr = a_op + imm_x;
      endcase
    end
  end
endmodule

// File: rtl/vldst_addr_seq.sv
module vldst_addr_seq
  import vldst_pkg::*;
#(
  parameter int AW    = 64,
  parameter int IMMW  = 16,
  parameter int VLMAX = 8,
  localparam int IW   = $clog2(VLMAX),
  localparam int VLW  = IW + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_indexed,
  input  logic                req_elstride,
  input  logic                req_base_isvec,
  input  logic                req_idx_isvec,
  input  logic                req_dst_isvec,
  input  logic                req_signed_idx,
  input  logic [1:0]          req_idx_width,
  input  logic [1:0]          req_op_width,
  input  logic                req_nocache,
  input  logic [IMMW-1:0]     req_imm,
  input  logic [VLW-1:0]      req_vl,
  input  logic [VLMAX-1:0]    req_src_mask,
  input  logic [VLMAX-1:0]    req_dst_mask,
  input  logic [AW-1:0]       req_base,
  input  logic [VLMAX*AW-1:0] req_base_vec,
  input  logic [AW-1:0]       req_idx,
  input  logic [VLMAX*AW-1:0] req_idx_vec,
  output logic                elem_valid,
  input  logic                elem_ready,
  output logic [AW-1:0]       elem_addr,
  output logic [IW-1:0]       elem_dst_idx,
  output logic                elem_nocache,
  output logic                done,
  output logic                done_illegal
);
  logic rst_s_n;
  vldst_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n));

  // decode of the incoming request
  vmode_e dec_mode;
  logic   dec_src_skip, dec_illegal;
  vldst_mode_dec u_dec (
    .indexed(req_indexed), .elstride(req_elstride), .base_isvec(req_base_isvec),
    .idx_isvec(req_idx_isvec), .dst_isvec(req_dst_isvec),
    .mode(dec_mode), .src_skip(dec_src_skip), .illegal(dec_illegal)
  );

  // control state
  seq_state_e     state_q, state_d;
  logic [VLW-1:0] i_q, i_d, j_q, j_d;
  logic           iss_q, iss_d;
  logic           cap_en;
  vmode_e         mode_q;
  logic           src_skip_q, dst_vec_q, ill_q;

  // captured operands
  logic [VLW-1:0]      vl_q;
  logic [VLMAX-1:0]    smask_q, dmask_q;
  logic [AW-1:0]       base_q, idx_q;
  logic [VLMAX*AW-1:0] bvec_q, ivec_q;
  logic                bisv_q, iisv_q, isgn_q, nc_q;
  logic [1:0]          iwc_q, opwc_q;
  logic [IMMW-1:0]     imm_q;

  // next enabled source and destination elements
  logic          s_found, d_found;
  logic [IW-1:0] s_pos, d_pos;

  vldst_next_set #(.N(VLMAX), .CW(VLW)) u_src_walk (
    .mask(smask_q), .start(i_q), .limit(vl_q), .skip(src_skip_q),
    .found(s_found), .pos(s_pos)
  );
  vldst_next_set #(.N(VLMAX), .CW(VLW)) u_dst_walk (
    .mask(dmask_q), .start(j_q), .limit(vl_q), .skip(dst_vec_q),
    .found(d_found), .pos(d_pos)
  );

  logic [AW-1:0] addr_w;
  vldst_addr_gen #(.AW(AW), .IMMW(IMMW), .VLMAX(VLMAX)) u_agen (
    .mode(mode_q), .base(base_q), .base_vec(bvec_q), .base_isvec(bisv_q),
    .idx(idx_q), .idx_vec(ivec_q), .idx_isvec(iisv_q), .idx_wcode(iwc_q),
    .idx_signed(isgn_q), .op_wcode(opwc_q), .imm(imm_q), .pos(s_pos),
    .addr(addr_w)
  );

  logic running, more, hs;
  assign running      = (state_q == S_RUN);
  assign more         = s_found && d_found && !ill_q && !(!dst_vec_q && iss_q);
  assign elem_valid   = running && more;
  assign done         = running && !more;
  assign done_illegal = done && ill_q;
  assign hs           = elem_valid && elem_ready;
  assign req_ready    = (state_q == S_IDLE) && rst_s_n;
  assign elem_addr    = addr_w;
  assign elem_dst_idx = d_pos;
  assign elem_nocache = nc_q;

  // next state
  always_comb begin
    state_d = state_q;
    i_d     = i_q;
    j_d     = j_q;
    iss_d   = iss_q;
    cap_en  = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (req_valid && req_ready) begin
          state_d = S_RUN;
          i_d     = '0;
          j_d     = '0;
          iss_d   = 1'b0;
          cap_en  = 1'b1;
        end
      end
      default: begin
        if (hs) begin
          i_d   = VLW'({1'b0, s_pos}) + VLW'(1);
          j_d   = VLW'({1'b0, d_pos}) + VLW'(1);
          iss_d = 1'b1;
        end else if (done) begin
          state_d = S_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q    <= S_IDLE;
      i_q        <= '0;
      j_q        <= '0;
      iss_q      <= 1'b0;
      mode_q     <= MD_UNIT;
      src_skip_q <= 1'b0;
      dst_vec_q  <= 1'b0;
      ill_q      <= 1'b0;
      vl_q       <= '0;
    end else begin
      state_q <= state_d;
      i_q     <= i_d;
      j_q     <= j_d;
      iss_q   <= iss_d;
      if (cap_en) begin
        mode_q     <= dec_mode;
        src_skip_q <= dec_src_skip;
        dst_vec_q  <= req_dst_isvec;
        ill_q      <= dec_illegal;
        vl_q       <= req_vl;
      end
    end
  end

  // operand capture, no reset needed
  always_ff @(posedge clk) begin
    if (cap_en) begin
      smask_q <= req_src_mask;
      dmask_q <= req_dst_mask;
      base_q  <= req_base;
      bvec_q  <= req_base_vec;
      bisv_q  <= req_base_isvec;
      idx_q   <= req_idx;
      ivec_q  <= req_idx_vec;
      iisv_q  <= req_idx_isvec;
      iwc_q   <= req_idx_width;
      isgn_q  <= req_signed_idx;
      opwc_q  <= req_op_width;
      imm_q   <= req_imm;
      nc_q    <= req_nocache;
    end
  end

  // assertions
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_s_n)
    (elem_valid && !elem_ready) |=> (elem_valid && $stable(elem_addr)
      && $stable(elem_dst_idx) && $stable(elem_nocache)));

  p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |=> req_ready);

  p_busy_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    (req_valid && req_ready) |=> !req_ready);

  p_dst_order_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (elem_valid && $past(hs)) |-> (elem_dst_idx > $past(elem_dst_idx)));

  p_splat_same_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode_q == MD_SPLAT && elem_valid && $past(hs)) |-> (elem_addr == $past(elem_addr)));

  p_unit_step_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode_q == MD_UNIT && elem_valid && $past(hs))
      |-> (elem_addr == $past(elem_addr) + (AW'(1) << opwc_q)));

  p_single_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!dst_vec_q && running && $past(hs)) |-> !elem_valid);

  p_illegal_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (req_valid && req_ready && dec_illegal) |=> (done && done_illegal));

  p_empty_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    (req_valid && req_ready && req_vl == '0) |=> (done && !elem_valid));

endmodule

// File: tb/vldst_addr_seq_tb.sv
module vldst_addr_seq_tb;
  localparam int AW = 64, IMMW = 16, VLMAX = 8, IW = 3, VLW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                rst_n, req_valid, req_ready;
  logic                req_indexed, req_elstride, req_base_isvec, req_idx_isvec, req_dst_isvec;
  logic                req_signed_idx, req_nocache;
  logic [1:0]          req_idx_width, req_op_width;
  logic [IMMW-1:0]     req_imm;
  logic [VLW-1:0]      req_vl;
  logic [VLMAX-1:0]    req_src_mask, req_dst_mask;
  logic [AW-1:0]       req_base, req_idx;
  logic [VLMAX*AW-1:0] req_base_vec, req_idx_vec;
  logic                elem_valid, elem_ready, elem_nocache, done, done_illegal;
  logic [AW-1:0]       elem_addr;
  logic [IW-1:0]       elem_dst_idx;

  vldst_addr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_indexed(req_indexed), .req_elstride(req_elstride),
    .req_base_isvec(req_base_isvec), .req_idx_isvec(req_idx_isvec),
    .req_dst_isvec(req_dst_isvec), .req_signed_idx(req_signed_idx),
    .req_idx_width(req_idx_width), .req_op_width(req_op_width),
    .req_nocache(req_nocache), .req_imm(req_imm), .req_vl(req_vl),
    .req_src_mask(req_src_mask), .req_dst_mask(req_dst_mask),
    .req_base(req_base), .req_base_vec(req_base_vec), .req_idx(req_idx),
    .req_idx_vec(req_idx_vec), .elem_valid(elem_valid), .elem_ready(elem_ready),
    .elem_addr(elem_addr), .elem_dst_idx(elem_dst_idx), .elem_nocache(elem_nocache),
    .done(done), .done_illegal(done_illegal)
  );

  int    total = 0;
  int    bad = 0;
  string cur_tag = "R1";
  bit    exp_busy = 0, exp_ill = 0, pend = 0, stall_prev = 0, chk_on = 0;
  logic [AW-1:0] q_addr[$];
  int            q_idx[$];

  task automatic chk(input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    string t;
    total++;
    t = stall_prev ? {cur_tag, " R12"} : cur_tag;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", t, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] ext_idx(input logic [AW-1:0] v);
    int bits;
    logic [AW-1:0] m;
    bits = 8 << req_idx_width;
    if (bits >= AW) return v;
    m = (64'd1 << bits) - 64'd1;
    if (req_signed_idx && v[bits-1]) return v | ~m;
    return v & m;
  endfunction

  function automatic logic [AW-1:0] exp_addr(input int i);
    logic [AW-1:0] a, b, immx;
    immx = {{(AW-IMMW){req_imm[IMMW-1]}}, req_imm};
    a = req_base_isvec ? req_base_vec[i*AW +: AW] : req_base;
    if (req_indexed) begin
      b = req_idx_isvec ? req_idx_vec[i*AW +: AW] : req_idx;
      return a + ext_idx(b);
    end
    if (req_base_isvec || !req_dst_isvec) return a + immx;
    if (req_elstride) return req_base + AW'(i) * immx;
    return req_base + immx + AW'(i) * (64'd1 << req_op_width);
  endfunction

  task automatic load_model();
    int  i, j, vl;
    bit  srcv, dstv;
    vl = int'(req_vl);
    exp_ill = req_indexed && !req_dst_isvec && (req_base_isvec || req_idx_isvec);
    srcv = req_indexed ? (req_base_isvec || req_idx_isvec) : req_base_isvec;
    dstv = req_dst_isvec;
    q_addr.delete();
    q_idx.delete();
    i = 0;
    j = 0;
    if (!exp_ill) begin
      while (i < vl && j < vl) begin
        if (srcv) while (i < vl && !req_src_mask[i]) i++;
        if (dstv) while (j < vl && !req_dst_mask[j]) j++;
        if (i >= vl || j >= vl) break;
        q_addr.push_back(exp_addr(i));
        q_idx.push_back(j);
        if (!dstv) break;
        i++;
        j++;
      end
    end
    exp_busy = 1;
  endtask

  task automatic cyc();
    bit rdy;
    @(negedge clk);
    if (chk_on) begin
      if (exp_busy) begin
        chk("req_ready", 64'(req_ready), 64'd0);
        if (q_addr.size() > 0) begin
          chk("elem_valid", 64'(elem_valid), 64'd1);
          chk("done", 64'(done), 64'd0);
          chk("elem_addr", elem_addr, q_addr[0]);
          chk("elem_dst_idx", 64'(elem_dst_idx), 64'(q_idx[0]));
          chk("elem_nocache", 64'(elem_nocache), 64'(req_nocache));
        end else begin
          chk("elem_valid", 64'(elem_valid), 64'd0);
          chk("done", 64'(done), 64'd1);
          chk("done_illegal", 64'(done_illegal), 64'(exp_ill));
        end
      end else begin
        chk("idle req_ready", 64'(req_ready), 64'd1);
        chk("idle elem_valid", 64'(elem_valid), 64'd0);
        chk("idle done", 64'(done), 64'd0);
      end
    end
    rdy = ($urandom_range(0, 3) != 0);
    elem_ready = rdy;
    req_valid  = pend;
    if (exp_busy) begin
      if (q_addr.size() > 0) begin
        stall_prev = !rdy;
        if (rdy) begin
          void'(q_addr.pop_front());
          void'(q_idx.pop_front());
        end
      end else begin
        exp_busy   = 0;
        stall_prev = 0;
        cur_tag    = "R1";
      end
    end else if (pend) begin
      load_model();
      pend = 0;
    end
  endtask

  task automatic go(input string tag);
    cyc();
    while (exp_busy) cyc();
    cur_tag = tag;
    pend = 1;
    cyc();
    cur_tag = tag;
    while (exp_busy) cyc();
  endtask

  task automatic defaults();
    req_indexed = 0; req_elstride = 0; req_base_isvec = 0; req_idx_isvec = 0;
    req_dst_isvec = 1; req_signed_idx = 0; req_idx_width = 2'd3; req_op_width = 2'd3;
    req_nocache = 0; req_imm = '0; req_vl = 4'd8;
    req_src_mask = 8'hFF; req_dst_mask = 8'hFF;
    req_base = 64'h1000; req_idx = 64'h0;
    for (int k = 0; k < VLMAX; k++) begin
      req_base_vec[k*AW +: AW] = 64'h4000_0000 + 64'(k) * 64'h330;
      req_idx_vec[k*AW +: AW]  = 64'hFFFF_FFFF_FFFF_8000 + 64'(k) * 64'h1FF1;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R1 act=%0d exp=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; req_valid = 0; elem_ready = 0;
    defaults();
    repeat (3) @(negedge clk);
    cur_tag = "R1";
    chk("reset req_ready", 64'(req_ready), 64'd0);
    chk("reset elem_valid", 64'(elem_valid), 64'd0);
    chk("reset done", 64'(done), 64'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk_on = 1;

    defaults(); req_vl = 4'd5; req_imm = 16'h0010;                          go("R2");
    defaults(); req_op_width = 2'd1; req_dst_mask = 8'b1011_0101;           go("R2 R8");
    defaults(); req_elstride = 1; req_vl = 4'd4; req_base = 64'h8000;
                req_imm = 16'hFFE8;                                         go("R3");
    defaults(); req_base_isvec = 1; req_imm = 16'h0008;
                req_src_mask = 8'b0110_1110; req_dst_mask = 8'b1101_1011;   go("R4 R8");
    defaults(); req_indexed = 1; req_idx_isvec = 1; req_idx_width = 2'd1;
                req_signed_idx = 1;                                         go("R5 R6");
    defaults(); req_indexed = 1; req_idx_isvec = 1; req_idx_width = 2'd1;
                req_signed_idx = 0; req_src_mask = 8'b1010_0110;            go("R6 R8");
    defaults(); req_indexed = 1; req_base_isvec = 1; req_idx_width = 2'd2;
                req_signed_idx = 1; req_idx = 64'h0000_0000_FFFF_FFF0;      go("R5 R6");
    defaults(); req_indexed = 1; req_idx = 64'h40; req_nocache = 1;
                req_vl = 4'd6; req_dst_mask = 8'b0010_1101;                 go("R7");
    defaults(); req_base_isvec = 1; req_dst_isvec = 0;
                req_src_mask = 8'b0001_1000; req_imm = 16'h0004;            go("R9");
    defaults(); req_indexed = 1; req_dst_isvec = 0; req_idx = 64'h7;        go("R9");
    defaults(); req_indexed = 1; req_dst_isvec = 0; req_idx_isvec = 1;      go("R10");
    defaults(); req_vl = 4'd0;                                              go("R11");
    defaults(); req_dst_mask = 8'h00; req_base_isvec = 1;                   go("R11");
    defaults(); req_src_mask = 8'b1111_0000; req_vl = 4'd4;
                req_base_isvec = 1;                                         go("R11 R8");
    defaults(); req_idx_isvec = 1; req_signed_idx = 1; req_idx_width = 2'd0;
                req_idx = 64'hFF; req_op_width = 2'd2; req_imm = 16'hFFF0;  go("R6 R2");
    defaults(); req_elstride = 1; req_imm = 16'h0100; req_nocache = 1;
                req_dst_mask = 8'b1000_0001;                                go("R3 R8");
    cyc(); cyc();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule